// File: doc/BRIEF.md
# I2C Target with Pin-Strapped Address

This block is a bus target for a two-wire I2C link, built to run entirely in the system clock domain. It samples the bus clock and data lines with the system clock, cleans them with a synchronizer and a short glitch filter, and finds start and stop conditions on the filtered copies. After each start it collects one address byte. It answers only when the seven address bits equal a fixed three-bit prefix followed by two two-bit strap codes. The strap codes come from board-level pins that a separate circuit has already decoded. With four levels on each of the two codes, sixteen targets can share one bus.

When the direction bit asks for a write, the first byte that follows is handed out on a command strobe, and every later byte goes out on a separate data strobe. When the direction bit asks for a read, the block takes bytes from a show-ahead byte source and shifts them out MSB first. It keeps sending until the controller answers a byte with a not-acknowledge. A start seen at any point, including in the middle of a byte, abandons the current transfer and begins address reception again. This lets a controller write a command and then read without issuing a stop in between. The data line is open-drain, so the block only reports when it pulls the line low.

Top module: `i2c_strap_target`

## Requirements
- R1: The target address is the 7-bit value {3'b011, strap_hi, strap_lo}. The first byte after a start carries the address in bits 7..1 and the direction in bit 0, where 0 means write and 1 means read. On a match the target pulls SDA low during the ninth bus clock, so the controller reads 0 in that clock's high phase.
- R2: On an address mismatch the target never pulls SDA low and raises no strobe until the next start condition. This holds through all later bytes of the transfer.
- R3: In a write transfer, the first byte after the address produces one cmd_valid pulse with that byte on cmd_byte. The byte is acknowledged (SDA low on its ninth clock), and cmd_valid and wr_valid are never high together.
- R4: In a write transfer, each byte after the command byte produces one single-cycle wr_valid pulse with the byte on wr_byte, in bus order. Each of these bytes is acknowledged.
- R5: In a read transfer, each byte is taken from rd_byte and sent MSB first. rd_req pulses for one cycle each time a byte is taken, so the source must present the next byte after that pulse.
- R6: In a read transfer, a controller acknowledge (SDA low on the ninth clock) makes the target send another byte. A not-acknowledge (SDA high) ends the transfer: SDA is released, and rd_req does not pulse again.
- R7: A start condition (SDA falling while SCL is high), including one in the middle of a byte or of a transfer, releases SDA and restarts address reception. A command write followed at once by a read therefore works without a stop.
- R8: A stop condition (SDA rising while SCL is high) releases SDA and returns the target to idle. The next start is then served normally.
- R9: The target only starts pulling SDA low while SCL is low.
- R10: After reset, sda_oe, cmd_valid, wr_valid and rd_req are all 0.
- R11: An SCL pulse lasting one system clock is ignored. The byte being transferred arrives intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the bus bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| strap_hi | input | 2 | Decoded upper strap code, address bits 3..2 |
| strap_lo | input | 2 | Decoded lower strap code, address bits 1..0 |
| rd_byte | input | 8 | Next byte to send in a read, shown ahead |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| cmd_valid | output | 1 | One-cycle strobe for the command byte |
| cmd_byte | output | 8 | Command byte, valid with cmd_valid |
| wr_valid | output | 1 | One-cycle strobe for each later written byte |
| wr_byte | output | 8 | Written byte, valid with wr_valid |
| rd_req | output | 1 | One-cycle pulse: rd_byte was taken |

## Verification
The bench builds the block with its default two-sample filter and the 3'b011 prefix, and runs the bus with 25-clock phases. That leaves room for the filter and edge delay inside each low phase, and lets a one-clock SCL spike test the filter. The strap inputs are changed between transfers over the all-zero, mixed and all-one codes, so each address bit is seen matching and failing to match. The timing also gives enough slack to abort a byte with a start after four bits and to chain a command write into a read.

// File: rtl/i2c_strap_target.sv
module i2c_strap_target #(
  parameter int         FILT   = 2,
  parameter logic [2:0] PREFIX = 3'b011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] strap_hi,
  input  logic [1:0] strap_lo,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       cmd_valid,
  output logic [7:0] cmd_byte,
  output logic       wr_valid,
  output logic [7:0] wr_byte,
  output logic       rd_req
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_TX, S_RACK} st_t;

  logic [1:0]      scl_sy, sda_sy;
  logic [FILT-1:0] scl_h, sda_h;
  logic            scl_f, sda_f, scl_d, sda_d;
  st_t             state;
  logic [3:0]      cnt;
  logic [7:0]      sr, tx;
  logic            rd, first, more;

  wire [6:0] my_addr = {PREFIX, strap_hi, strap_lo};
  wire [7:0] sr_next = {sr[6:0], sda_f};
  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire start_c  = sda_d & ~sda_f & scl_f & scl_d;
  wire stop_c   = ~sda_d & sda_f & scl_f & scl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1;
      scl_h  <= '1; sda_h  <= '1;
      scl_f  <= 1'b1; sda_f <= 1'b1;
      scl_d  <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_h  <= {scl_h[FILT-2:0], scl_sy[1]};
      sda_h  <= {sda_h[FILT-2:0], sda_sy[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sr <= '0; tx <= '0;
      rd <= 1'b0; first <= 1'b0; more <= 1'b0;
      sda_oe <= 1'b0; cmd_valid <= 1'b0; wr_valid <= 1'b0; rd_req <= 1'b0;
      cmd_byte <= '0; wr_byte <= '0;
    end else begin
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      rd_req    <= 1'b0;
      if (start_c) begin
        state <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        state <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WDAT: if (scl_rise) begin
            sr  <= sr_next;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              if (state == S_ADDR) begin
                if (sr[6:0] == my_addr) begin
                  rd <= sda_f; first <= 1'b1; state <= S_AACK;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                if (first) begin cmd_valid <= 1'b1; cmd_byte <= sr_next; end
                else       begin wr_valid  <= 1'b1; wr_byte  <= sr_next; end
                first <= 1'b0;
                state <= S_WACK;
              end
            end
          end
          S_AACK, S_WACK: if (scl_fall) begin
            if (!sda_oe) sda_oe <= 1'b1;
            else begin
              cnt <= '0;
              if (state == S_AACK && rd) begin
                state <= S_TX; tx <= rd_byte; sda_oe <= ~rd_byte[7]; rd_req <= 1'b1;
              end else begin
                state <= S_WDAT; sda_oe <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; state <= S_RACK;
              end else begin
                tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) more <= ~sda_f;
            if (scl_fall) begin
              cnt <= '0;
              if (more) begin
                state <= S_TX; tx <= rd_byte; sda_oe <= ~rd_byte[7]; rd_req <= 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic cmd_valid,
  input logic wr_valid,
  input logic rd_req,
  input logic scl_f,
  input logic start_c,
  input logic stop_c
);
  a_r9_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);
  a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);
  a_r7_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !sda_oe);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && wr_valid));
  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
endmodule

bind i2c_strap_target i2c_strap_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .cmd_valid(cmd_valid),
  .wr_valid(wr_valid), .rd_req(rd_req), .scl_f(scl_f),
  .start_c(start_c), .stop_c(stop_c)
);

// File: tb/i2c_strap_target_tb.sv
module i2c_strap_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap_hi = 2'b00, strap_lo = 2'b00;
  logic [7:0] rd_mem [4];
  int rd_ptr = 0, rd_seen = 0;
  logic [7:0] rd_byte;
  logic sda_oe, cmd_valid, wr_valid, rd_req;
  logic [7:0] cmd_byte, wr_byte;
  wire sda_bus = m_sda & ~sda_oe;
  logic [7:0] exp_cmd[$], exp_wr[$];
  int tests = 0, fails = 0;
  bit quiet = 0, prev_oe = 0;

  assign rd_byte = rd_mem[rd_ptr % 4];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_strap_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .strap_hi(strap_hi), .strap_lo(strap_lo), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin
      if (exp_cmd.size() == 0) chk("R3 unexpected cmd_valid", cmd_byte, -1);
      else chk("R3 command byte", cmd_byte, exp_cmd.pop_front());
    end
    if (wr_valid) begin
      if (exp_wr.size() == 0) chk("R4 unexpected wr_valid", wr_byte, -1);
      else chk("R4 data byte", wr_byte, exp_wr.pop_front());
    end
    if (rd_req) begin rd_ptr++; rd_seen++; end
    if (sda_oe && !prev_oe && m_scl) chk("R9 drive began with SCL high", 1, 0);
    if (quiet && sda_oe) chk("R2 drive after mismatch", 1, 0);
    prev_oe = sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    wt(8); m_sda = 1'b1; wt(H-8); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    wt(8); m_sda = 1'b0; wt(H-8); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      wt(8); m_sda = b[i]; wt(H-8);
      if (glitch && i == 4) begin m_scl = 1'b1; wt(1); m_scl = 1'b0; wt(3); end
      m_scl = 1'b1; wt(H); m_scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    send_bits(b, 8, glitch);
    wt(8); m_sda = 1'b1; wt(H-8); m_scl = 1'b1; wt(H/2); ack = sda_bus; wt(H - H/2); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input bit ack_it, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      wt(8); m_sda = 1'b1; wt(H-8); m_scl = 1'b1; wt(H/2); d[i] = sda_bus; wt(H - H/2); m_scl = 1'b0;
    end
    wt(8); m_sda = ~ack_it; wt(H-8); m_scl = 1'b1; wt(H); m_scl = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    rd_mem[0] = 8'hC3; rd_mem[1] = 8'h5A; rd_mem[2] = 8'h81; rd_mem[3] = 8'h00;
    wt(5); rst_n = 1'b1; wt(2);
    chk("R10 sda_oe after reset", sda_oe, 0);
    chk("R10 cmd_valid after reset", cmd_valid, 0);
    chk("R10 wr_valid after reset", wr_valid, 0);
    chk("R10 rd_req after reset", rd_req, 0);

    // R1 R3 R4: straps 00/00 -> 0x60 write
    bus_start;
    send_byte(8'h60, 0, a); chk("R1 ack for 0x60", a, 0);
    exp_cmd.push_back(8'hA5);
    send_byte(8'hA5, 0, a); chk("R3 command acked", a, 0);
    exp_wr.push_back(8'h3C);
    send_byte(8'h3C, 0, a); chk("R4 data acked", a, 0);
    exp_wr.push_back(8'hF0);
    send_byte(8'hF0, 0, a); chk("R4 second data acked", a, 0);
    bus_stop; wt(10);
    chk("R8 released after stop", sda_oe, 0);

    // R1: straps 10/01 -> 0x72
    strap_hi = 2'b10; strap_lo = 2'b01; wt(4);
    bus_start;
    send_byte(8'h72, 0, a); chk("R1 ack for 0x72", a, 0);
    exp_cmd.push_back(8'h11);
    send_byte(8'h11, 0, a); chk("R3 command after 0x72", a, 0);
    bus_stop; wt(10);

    // R2: 0x60 no longer matches
    quiet = 1;
    bus_start;
    send_byte(8'h60, 0, a); chk("R2 no ack on mismatch", a, 1);
    send_byte(8'h55, 0, a); chk("R2 later byte not acked", a, 1);
    bus_stop; wt(10);
    quiet = 0;

    // R5 R6: straps 11/11 -> read 0x7F
    strap_hi = 2'b11; strap_lo = 2'b11; rd_ptr = 0; rd_seen = 0; wt(4);
    bus_start;
    send_byte(8'h7F, 0, a); chk("R1 ack for read 0x7F", a, 0);
    recv_byte(1, d); chk("R5 read byte 0", d, 8'hC3);
    recv_byte(1, d); chk("R6 read byte 1 after ack", d, 8'h5A);
    recv_byte(0, d); chk("R5 read byte 2", d, 8'h81);
    wt(10);
    chk("R6 released after nack", sda_oe, 0);
    chk("R6 rd_req count", rd_seen, 3);
    bus_stop; wt(10);

    // R7: abort mid-address, then command write chained into read
    rd_ptr = 1; rd_seen = 0;
    bus_start;
    send_bits(8'h7E, 4, 0);
    bus_start;
    send_byte(8'h7E, 0, a); chk("R7 ack after mid-byte restart", a, 0);
    exp_cmd.push_back(8'h42);
    send_byte(8'h42, 0, a); chk("R7 command before repeated start", a, 0);
    bus_start;
    send_byte(8'h7F, 0, a); chk("R7 read address after repeated start", a, 0);
    recv_byte(0, d); chk("R7 read byte after repeated start", d, 8'h5A);
    bus_stop; wt(10);
    chk("R7 one byte taken", rd_seen, 1);

    // R11: one-cycle SCL spike inside the command byte
    bus_start;
    send_byte(8'h7E, 0, a); chk("R11 address ack", a, 0);
    exp_cmd.push_back(8'h5E);
    send_byte(8'h5E, 1, a); chk("R11 command acked despite spike", a, 0);
    exp_wr.push_back(8'h01);
    send_byte(8'h01, 0, a); chk("R11 following byte acked", a, 0);
    bus_stop; wt(20);

    chk("R3 all commands delivered", exp_cmd.size(), 0);
    chk("R4 all data delivered", exp_wr.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule